// File: doc/BRIEF.md
# Byte SPI Controller with Master-Contention Fallback

This block is a byte-wide SPI port that works either as bus master or as bus slave, chosen by a control bit. A small register interface gives access to a control register, a status register and a data register. As master it generates SCK from the system clock with a selectable divider and shifts eight bits out on MOSI while it samples MISO. As slave it follows an external SCK while its select pin is low. It shifts in from MOSI and drives MISO only when software allows it. Every output pin has its own output-enable, so the pads stay outside the block.

The select pin is always watched through a two-flop synchronizer. If that pin is configured as an input and goes low while the block is master, the block takes it as another master claiming the bus. It clears its own master bit, releases SCK and MOSI, and raises the completion flag. It then stays a slave until software writes the master bit again. In slave mode a high select is an idle bus: clocks are ignored, the bit counter returns to zero and a partly received byte is dropped.

Register map: address 0 control, address 1 status, address 2 data. Control bits: bit 0 enable, bit 1 master, bits 3:2 divider select, bit 4 interrupt enable, bit 5 select-is-output, bit 6 slave MISO drive enable. Status bits: bit 7 completion flag, bit 0 master busy. Read data appears on `reg_rdata` one clock after `reg_rd`.

Top module: `spi_modefault_ctrl`

## Requirements
- R1: After reset all three output-enables, `irq`, the control register and the status register read 0.
- R2: With enable and master set and the port idle, a write to the data register starts an 8-bit transfer, MSB first. MOSI changes on falling SCK and MISO is sampled on rising SCK. The received byte is then returned by a data register read.
- R3: Divider select values 0, 1, 2 and 3 give SCK periods of 4, 16, 64 and 128 system clocks. SCK idles low.
- R4: The completion flag (status bit 7) sets at the end of every byte. A status read that sees the flag, followed by a data register access, clears it. A pulse on `irq_ack` also clears it.
- R5: `irq` is high one clock after the flag, control bit 4 and `glb_irq_en` are all high, and it is low one clock after the flag is low.
- R6: When enable and master are set and control bit 5 is 0, a low `ss_in` clears the master bit, drops `sck_oe` and `mosi_oe`, aborts any transfer and sets the flag, all within 4 clocks. The master bit stays 0 until software writes it to 1.
- R7: With control bit 5 set, `ss_in` has no effect in master mode.
- R8: In slave mode with `ss_in` low, the block captures MOSI on rising `sck_in` and shifts its loaded byte out on `miso_out`, MSB first, changing after falling edges. `miso_oe` is high only if control bit 6 is set.
- R9: In slave mode a high `ss_in` releases `miso_oe`, ignores `sck_in` and `mosi_in`, and discards any partial byte. The next byte starts again at bit 7 of the loaded transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after reg_rd |
| irq_ack | input | 1 | Clears the completion flag |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Generated SCK in master mode |
| sck_oe | output | 1 | SCK output enable |
| sck_in | input | 1 | SCK from the bus in slave mode |
| mosi_out | output | 1 | Serial data out in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_in | input | 1 | Serial data in in slave mode |
| miso_out | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | MISO output enable |
| miso_in | input | 1 | Serial data in in master mode |
| ss_in | input | 1 | Select pin level |

## Verification
A wrong bit counter shows up within one byte: the flag sets early or late, and the byte read back is shifted. A wrong divider shows up in the time between the first two SCK rises. A stuck mode or a stuck select synchronizer shows up within a few clocks of a select change. Either the output-enables fail to drop, or the master bit still reads 1. A slave that keeps a partial byte after an abort returns a mixed byte on the next full transfer, and the bench exposes this by reading back a known pattern.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int HALF_MAX = 64;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       rsv;
    logic       miso_en;
    logic       ss_out;
    logic       irq_en;
    logic [1:0] div;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam int STAT_FLAG_BIT = 7;
  localparam int STAT_BUSY_BIT = 0;

  function automatic int half_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return HALF_MAX;
    endcase
  endfunction
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int          W        = 3,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen
  import spi_mf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       sck,
  output logic       rise,
  output logic       fall
);
  localparam int HW = $clog2(HALF_MAX);

  logic [HW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == HW'(half_cycles(sel) - 1));
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          sample,
  input  logic          shift,
  input  logic          din,
  output logic          msb,
  output logic          last,
  output logic [W-1:0]  rx,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] sh;
  logic         cap;

  assign msb  = sh[W-1];
  assign last = shift && !clear && !load && (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cap <= 1'b0;
      cnt <= '0;
      rx  <= '0;
    end else if (clear || load) begin
      sh  <= load_val;
      cnt <= '0;
    end else begin
      if (sample) cap <= din;
      if (shift) begin
        if (last) begin
          rx  <= {sh[W-2:0], cap};
          sh  <= load_val;
          cnt <= '0;
        end else begin
          sh  <= {sh[W-2:0], cap};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_modefault_ctrl.sv
module spi_modefault_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_ack,
  input  logic          glb_irq_en,
  output logic          irq,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sck_in,
  output logic          mosi_out,
  output logic          mosi_oe,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          miso_in,
  input  logic          ss_in
);
  localparam int CW = $clog2(DW);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t          ctrl_q, ctrl_d;
  logic           ss_s, sck_s, mosi_s, sck_d;
  logic           busy, flag_q, armed;
  logic [DW-1:0]  tx_buf;
  logic           wr_ctrl, wr_data, rd_stat, rd_data, data_acc;
  logic           fault, start, slv_act, slv_rise, slv_fall;
  logic           m_rise, m_fall, sck_gen;
  logic           samp, shft, din, sh_clear;
  logic           sh_msb, last;
  logic [DW-1:0]  rx_word, load_val;
  logic [CW-1:0]  bit_cnt;

  // select, slave clock and slave data cross into the system clock
  spi_mf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_in, sck_in, mosi_in}),
    .q   ({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign rd_stat  = reg_rd && (reg_addr == A_STAT);
  assign rd_data  = reg_rd && (reg_addr == A_DATA);
  assign data_acc = wr_data || rd_data;

  // another master pulls select low while select is an input
  assign fault = ctrl_q.en && ctrl_q.master && !ctrl_q.ss_out && !ss_s;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (fault)   ctrl_d.master = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign start    = wr_data && ctrl_q.en && ctrl_q.master && !busy && !fault;
  assign slv_act  = ctrl_q.en && !ctrl_q.master && !ss_s;
  assign slv_rise = slv_act && sck_s && !sck_d;
  assign slv_fall = slv_act && !sck_s && sck_d;

  spi_mf_clkgen u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .sel  (ctrl_q.div),
    .sck  (sck_gen),
    .rise (m_rise),
    .fall (m_fall)
  );

  assign samp     = busy ? m_rise  : slv_rise;
  assign shft     = busy ? m_fall  : slv_fall;
  assign din      = busy ? miso_in : mosi_s;
  assign sh_clear = !ctrl_q.en || fault || (!ctrl_q.master && ss_s);
  assign load_val = wr_data ? reg_wdata : tx_buf;

  spi_mf_shifter #(.W(DW), .CW(CW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (sh_clear),
    .load     (start),
    .load_val (load_val),
    .sample   (samp),
    .shift    (shft),
    .din      (din),
    .msb      (sh_msb),
    .last     (last),
    .rx       (rx_word),
    .cnt      (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)                            busy <= 1'b0;
    else if (!ctrl_d.en || !ctrl_d.master) busy <= 1'b0;
    else if (start)                     busy <= 1'b1;
    else if (busy && last)              busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          tx_buf <= '0;
    else if (wr_data) tx_buf <= reg_wdata;
  end

  // completion flag: set wins over any clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (last || fault)                     flag_q <= 1'b1;
      else if (irq_ack || (armed && data_acc)) flag_q <= 1'b0;

      if (irq_ack || data_acc)   armed <= 1'b0;
      else if (rd_stat && flag_q) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= DW'(ctrl_q);
        A_STAT: begin
          reg_rdata                <= '0;
          reg_rdata[STAT_FLAG_BIT] <= flag_q;
          reg_rdata[STAT_BUSY_BIT] <= busy;
        end
        A_DATA:  reg_rdata <= rx_word;
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe  <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
      irq     <= 1'b0;
    end else begin
      sck_oe  <= ctrl_d.en && ctrl_d.master;
      mosi_oe <= ctrl_d.en && ctrl_d.master;
      miso_oe <= ctrl_d.en && !ctrl_d.master && ctrl_d.miso_en && !ss_s;
      irq     <= flag_q && ctrl_q.irq_en && glb_irq_en;
    end
  end

  assign sck_out  = sck_gen;
  assign mosi_out = sh_msb;
  assign miso_out = sh_msb;
endmodule

// File: rtl/spi_mf_checker.sv
module spi_mf_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_en,
  input logic          ctrl_master,
  input logic          ctrl_ssout,
  input logic          ctrl_irq_en,
  input logic          glb_irq_en,
  input logic          ss_s,
  input logic          flag,
  input logic          irq,
  input logic          sck_oe,
  input logic          miso_oe,
  input logic [CW-1:0] bit_cnt
);
  // R6: contention in master mode drops the master bit and raises the flag
  a_r6_fault_to_slave: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && ctrl_master && !ctrl_ssout && !ss_s) |=> (!ctrl_master && flag));

  // R5: interrupt follows the gated flag one clock later
  a_r5_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (flag && ctrl_irq_en && glb_irq_en) |=> irq);

  a_r5_irq_drop: assert property (@(posedge clk) disable iff (rst)
    !flag |=> !irq);

  // R9: idle select in slave mode clears the bit counter and releases MISO
  a_r9_idle_reset: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !ctrl_master && ss_s) |=> (bit_cnt == '0 && !miso_oe));

  // R8: the block never drives SCK and MISO together
  a_r8_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    sck_oe |-> !miso_oe);
endmodule

bind spi_modefault_ctrl spi_mf_checker #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_en     (ctrl_q.en),
  .ctrl_master (ctrl_q.master),
  .ctrl_ssout  (ctrl_q.ss_out),
  .ctrl_irq_en (ctrl_q.irq_en),
  .glb_irq_en  (glb_irq_en),
  .ss_s        (ss_s),
  .flag        (flag_q),
  .irq         (irq),
  .sck_oe      (sck_oe),
  .miso_oe     (miso_oe),
  .bit_cnt     (bit_cnt)
);

// File: tb/tb_spi_modefault_ctrl.sv
module tb_spi_modefault_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, irq_ack = 0, glb_irq_en = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, miso_in;
  logic sck_in = 0, mosi_in = 0, ss_in = 1;

  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_modefault_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .glb_irq_en(glb_irq_en), .irq(irq), .sck_out(sck_out), .sck_oe(sck_oe),
    .sck_in(sck_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe), .mosi_in(mosi_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .miso_in(miso_in), .ss_in(ss_in)
  );

  // bench-side slave for master transfers
  logic [7:0] slv_tx = 0, bm = 0;
  int fall_n = 0, base = 0;
  always @(negedge sck_out) fall_n <= fall_n + 1;
  always @(posedge sck_out) bm <= {bm[6:0], mosi_out};
  assign miso_in = ((fall_n - base) < 8) ? slv_tx[7 - (fall_n - base)] : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_xfer(input int sel, input logic [7:0] tx, input logic [7:0] sb);
    logic [7:0] d;
    time t1, t2;
    int n;
    n = 4 << (2 * sel);
    if (sel == 3) n = 128;
    slv_tx = sb; base = fall_n;
    wr(0, 8'h03 | 8'(sel << 2));
    wr(2, tx);
    @(posedge sck_out); t1 = $time;
    @(posedge sck_out); t2 = $time;
    chk((t2 - t1) == time'(n * 10), "R3 sck period", int'(t2 - t1), n * 10);
    idle(8 * n);
    rd(1, d);
    chk(d == 8'h80, "R4 flag set busy clear", d, 8'h80);
    chk(bm == tx, "R2 mosi byte", bm, tx);
    rd(2, d);
    chk(d == sb, "R2 miso byte", d, sb);
    rd(1, d);
    chk(d == 8'h00, "R4 flag cleared by status+data", d, 0);
  endtask

  task automatic slave_bits(input logic [7:0] b, input int nb, output logic [7:0] seen);
    seen = 0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); mosi_in = b[7-i];
      idle(8);
      seen = {seen[6:0], miso_out};
      sck_in = 1; idle(8);
      sck_in = 0; idle(8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, seen;
    logic [7:0] pats [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    // R1 reset state
    chk({sck_oe, mosi_oe, miso_oe, irq} == 4'b0, "R1 outputs", {sck_oe, mosi_oe, miso_oe, irq}, 0);
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 status", d, 0);

    // R2 R3 R4 sweep over all dividers and patterns
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        master_xfer(s, pats[p], ~pats[(p + s) % 4] ^ 8'(p * 17));

    // R5 interrupt gating and acknowledge
    glb_irq_en = 1;
    wr(0, 8'h13);
    slv_tx = 8'h5A; base = fall_n;
    wr(2, 8'h81);
    idle(40);
    chk(irq == 1, "R5 irq raised", irq, 1);
    glb_irq_en = 0; idle(2);
    chk(irq == 0, "R5 irq gated by global enable", irq, 0);
    glb_irq_en = 1; idle(2);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0; idle(2);
    chk(irq == 0, "R4 irq_ack clears flag", irq, 0);
    rd(1, d); chk(d[7] == 0, "R4 flag after ack", d, 0);

    // R6 mode fault with select as input
    chk(sck_oe == 1, "R6 master drives sck", sck_oe, 1);
    ss_in = 0; idle(4);
    chk({sck_oe, mosi_oe} == 2'b00, "R6 oe dropped", {sck_oe, mosi_oe}, 0);
    chk(irq == 1, "R6 irq on fault", irq, 1);
    rd(0, d); chk(d[1] == 0, "R6 master cleared", d, 8'h11);
    rd(1, d); chk(d[7] == 1, "R6 flag set", d, 8'h80);
    ss_in = 1; idle(6);
    rd(0, d); chk(d[1] == 0, "R6 stays slave", d, 8'h11);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    wr(0, 8'h03); idle(2);
    chk(sck_oe == 1, "R6 master restored", sck_oe, 1);

    // R6 fault in the middle of a transfer
    wr(0, 8'h0F);
    wr(2, 8'hC3);
    idle(300);
    ss_in = 0; idle(4);
    rd(1, d); chk(d == 8'h80, "R6 abort busy, flag set", d, 8'h80);
    ss_in = 1; idle(4);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;

    // R7 select as output has no effect
    wr(0, 8'h23);
    ss_in = 0; idle(6);
    rd(0, d); chk(d == 8'h23, "R7 master kept", d, 8'h23);
    chk(sck_oe == 1, "R7 sck_oe kept", sck_oe, 1);
    rd(1, d); chk(d == 0, "R7 no flag", d, 0);
    ss_in = 1;

    // R8 slave transfers with MISO enabled
    for (int p = 0; p < 4; p++) begin
      wr(0, 8'h41);
      wr(2, pats[p] ^ 8'h0F);
      ss_in = 0; idle(4);
      chk(miso_oe == 1, "R8 miso_oe while selected", miso_oe, 1);
      slave_bits(~pats[p], 8, seen);
      chk(seen == (pats[p] ^ 8'h0F), "R8 miso byte", seen, pats[p] ^ 8'h0F);
      rd(1, d); chk(d == 8'h80, "R8 flag", d, 8'h80);
      rd(2, d); chk(d == ~pats[p], "R8 rx byte", d, ~pats[p]);
      ss_in = 1; idle(4);
      chk(miso_oe == 0, "R9 miso_oe released", miso_oe, 0);
    end
    // R8 MISO drive disabled
    wr(0, 8'h01);
    ss_in = 0; idle(4);
    chk(miso_oe == 0, "R8 miso_oe needs enable bit", miso_oe, 0);
    ss_in = 1; idle(4);

    // R9 abort of a partial byte, then a full byte
    wr(0, 8'h41);
    wr(2, 8'h96);
    ss_in = 0; idle(4);
    slave_bits(8'hF0, 4, seen);
    ss_in = 1; idle(6);
    rd(1, d); chk(d == 0, "R9 no flag after partial", d, 0);
    ss_in = 0; idle(4);
    slave_bits(8'h5A, 8, seen);
    chk(seen == 8'h96, "R9 miso restarts at bit 7", seen, 8'h96);
    rd(1, d);
    rd(2, d); chk(d == 8'h5A, "R9 partial discarded", d, 8'h5A);
    ss_in = 1; idle(4);

    // R9 clocks ignored while deselected
    slave_bits(8'hFF, 8, seen);
    idle(4);
    rd(1, d); chk(d == 0, "R9 deselected clocks ignored", d, 0);
    rd(2, d); chk(d == 8'h5A, "R9 rx unchanged", d, 8'h5A);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule